// File: doc/BRIEF.md
# Prescaled Capture Timer

The block runs a free-running counter and takes a timestamp of it when a capture input rises. Capture events are not all stored: an event divider counts rising edges and only every Nth edge latches the counter. N comes from a 7-bit value that software may rewrite at any time. Stored timestamps wait in a four-entry queue until they are read, oldest first.

An interrupt line reports that a chosen number of timestamps (1 to 4) is waiting. A threshold of zero turns it off. A timestamp that arrives while the queue is full is dropped, and a sticky overflow flag records the loss until the next reset.

Top module: `cap_prescale_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), fifo_level is 0, rd_valid, irq and ovf are 0, and the divide value is 2.
- R2: The timer is 0 in the first cycle after reset and adds 1 every cycle. A stored timestamp equals the timer value in the cycle in which the triggering edge is seen on cap_in.
- R3: An event is a cycle with cap_in high after a cycle with cap_in low. A level held high for many cycles counts as one event.
- R4: With divide value N, the Nth event since the last store (or since the last divide write) stores a timestamp, and counting starts again from zero.
- R5: A cycle with div_wr high loads div_val and clears the event count. The new N applies from the next event. An event in the same cycle as the write is not counted.
- R6: A div_val of 0 or 1 is taken as 2. Values 2 to 127 are used as written.
- R7: The queue holds up to 4 timestamps. rd_data shows the oldest while rd_valid is high, and rd_en pops it.
- R8: A timestamp stored while the queue holds 4 entries (with no pop in that cycle) is discarded, leaves the contents unchanged, and sets ovf. ovf then stays high until reset.
- R9: irq_thr of 0 keeps irq low. Values 5 to 7 act as 4.
- R10: With irq_thr from 1 to 4, irq is high exactly while fifo_level is at least the threshold. It therefore stays high until reads bring the level below it.
- R11: rd_en while the queue is empty has no effect: the level stays 0 and ovf is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 1 | Capture input, rising edges count as events |
| div_wr | input | 1 | Write strobe for the divide value |
| div_val | input | 7 | New divide value N |
| irq_thr | input | 3 | Interrupt threshold, 0 = off |
| rd_en | input | 1 | Pop the oldest timestamp |
| rd_data | output | 16 | Oldest stored timestamp |
| rd_valid | output | 1 | Queue not empty |
| fifo_level | output | 3 | Number of stored timestamps |
| irq | output | 1 | Threshold interrupt |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The assertions expect cap_in to be synchronous to clk, and irq_thr to be held still across any cycle in which they compare the interrupt with the queue level. The stimulus drives every input on the falling edge. irq_thr changes only while the queue is idle. Divide writes never coincide with a capture edge, except where that coincidence is the case under test.

// File: rtl/cap_pkg.sv
// Shared widths and helpers for the prescaled capture timer.
// Assumes: divide value is 7 bits; minimum legal divide is 2.
package cap_pkg;
    localparam int DIV_W   = 7;
    localparam int DIV_MIN = 2;
    typedef logic [DIV_W-1:0] div_t;

    // Clamp a divide request to the legal lower limit.
    function automatic div_t clamp_div(input div_t v);
        return (v < div_t'(DIV_MIN)) ? div_t'(DIV_MIN) : v;
    endfunction
endpackage

// File: rtl/cap_timer_core.sv
// Free-running timestamp counter.
// Assumes: wraps at 2**CNT_W; cleared by synchronous active-low reset.
module cap_timer_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    // Advance the counter every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/cap_event_div.sv
// Rising-edge detector and event divider. Emits one fire pulse on
// every Nth rising edge of cap_in.
// Assumes: cap_in is synchronous to clk; a divide write wins over an
// event in the same cycle.
module cap_event_div
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_in,
    input  logic div_wr,
    input  div_t div_val,
    output logic fire
);
    logic cap_d;
    div_t n_q;
    div_t ev_cnt;
    logic edge_seen;

    assign edge_seen = cap_in && !cap_d;
    assign fire      = edge_seen && !div_wr && (ev_cnt == n_q - 1'b1);

    // Delay cap_in by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_d <= 1'b1;
        else        cap_d <= cap_in;
    end

    // Hold the clamped divide value.
    always_ff @(posedge clk) begin
        if (!rst_n)      n_q <= div_t'(DIV_MIN);
        else if (div_wr) n_q <= clamp_div(div_val);
    end

    // Count events, restarting on a store or a divide write.
    always_ff @(posedge clk) begin
        if (!rst_n || div_wr) ev_cnt <= '0;
        else if (fire)        ev_cnt <= '0;
        else if (edge_seen)   ev_cnt <= ev_cnt + 1'b1;
    end
endmodule

// File: rtl/cap_fifo.sv
// Shallow first-word-fall-through queue of timestamps with a sticky
// overflow flag.
// Assumes: DEPTH >= 2; a push into a full queue is accepted only if a
// pop happens in the same cycle.
module cap_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     wdata,
    input  logic             pop,
    output logic [W-1:0]     rdata,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic             ovf
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, pop_ok, push_ok;

    assign full    = (level == LVL_W'(DEPTH));
    assign pop_ok  = pop && (level != '0);
    assign push_ok = push && (!full || pop_ok);
    assign rdata   = mem[rd_ptr];

    // Pointer step with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Store accepted timestamps.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Move pointers and track fill level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            if (push_ok && !pop_ok)      level <= level + 1'b1;
            else if (pop_ok && !push_ok) level <= level - 1'b1;
        end
    end

    // Latch overflow when a store is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)               ovf <= 1'b0;
        else if (push && !push_ok) ovf <= 1'b1;
    end
endmodule

// File: rtl/cap_prescale_timer.sv
// Top: timer, event divider, timestamp queue and threshold interrupt.
// Assumes: inputs synchronous to clk; irq_thr 0 disables the interrupt,
// values above DEPTH act as DEPTH.
module cap_prescale_timer
    import cap_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_val,
    input  logic [LVL_W-1:0] irq_thr,
    input  logic             rd_en,
    output logic [CNT_W-1:0] rd_data,
    output logic             rd_valid,
    output logic [LVL_W-1:0] fifo_level,
    output logic             irq,
    output logic             ovf
);
    logic [CNT_W-1:0] timer_q;
    logic             fire;
    logic [LVL_W-1:0] thr_eff;

    cap_timer_core #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .count(timer_q)
    );

    cap_event_div div_i (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .div_wr(div_wr), .div_val(div_val), .fire(fire)
    );

    cap_fifo #(.W(CNT_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(fire), .wdata(timer_q),
        .pop(rd_en), .rdata(rd_data), .level(fifo_level), .ovf(ovf)
    );

    // Limit the threshold to the queue depth and compare with the level.
    always_comb begin
        thr_eff  = (irq_thr > LVL_W'(DEPTH)) ? LVL_W'(DEPTH) : irq_thr;
        irq      = (thr_eff != '0) && (fifo_level >= thr_eff);
        rd_valid = (fifo_level != '0);
    end
endmodule

// File: rtl/cap_prescale_timer_chk.sv
// Checker for the prescaled capture timer, bound to the top module.
// Assumes: irq_thr is held stable while level and irq are compared.
module cap_prescale_timer_chk #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 3,
    parameter int DEPTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] timer_q,
    input logic [LVL_W-1:0] irq_thr,
    input logic             rd_en,
    input logic [LVL_W-1:0] fifo_level,
    input logic             rd_valid,
    input logic             irq,
    input logic             ovf
);
    AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> timer_q == $past(timer_q) + 1'b1); // R2
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH)); // R7
    AST_VALID_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == (fifo_level != '0)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R8
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_thr == '0 |-> !irq); // R9
    AST_IRQ_ROSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq) && $stable(irq_thr)) |-> fifo_level > $past(fifo_level)); // R10
    AST_IRQ_FELL: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq) && $stable(irq_thr)) |-> fifo_level < $past(fifo_level)); // R10
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level == '0 && rd_en && !ovf) |=> !ovf); // R11
endmodule

bind cap_prescale_timer cap_prescale_timer_chk #(
    .CNT_W(CNT_W), .LVL_W(LVL_W), .DEPTH(DEPTH)
) chk_i (
    .clk(clk), .rst_n(rst_n), .timer_q(timer_q), .irq_thr(irq_thr),
    .rd_en(rd_en), .fifo_level(fifo_level), .rd_valid(rd_valid),
    .irq(irq), .ovf(ovf)
);

// File: tb/cap_prescale_timer_tb.sv
// Bench: table-driven divide runs, then directed reset and corner tests.
module cap_prescale_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_in = 1'b0;
    logic        div_wr = 1'b0;
    logic [6:0]  div_val = '0;
    logic [2:0]  irq_thr = '0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [2:0]  fifo_level;
    logic        irq;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int bcnt = 0;          // bench timer model
    int m_ev = 0, m_n = 2; // bench divider model
    int exp_q[$];
    logic m_ovf = 1'b0;

    // {divide value, number of pulses}
    localparam logic [13:0] VEC [5] = '{
        {7'd3, 7'd6}, {7'd0, 7'd4}, {7'd1, 7'd8}, {7'd5, 7'd10}, {7'd2, 7'd3}
    };

    always #5 clk = ~clk;

    cap_prescale_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .div_wr(div_wr),
        .div_val(div_val), .irq_thr(irq_thr), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .fifo_level(fifo_level),
        .irq(irq), .ovf(ovf)
    );

    always @(posedge clk) bcnt <= rst_n ? bcnt + 1 : 0;

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual timeout expected done");
        report();
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_ev = 0; m_n = 2; m_ovf = 1'b0; exp_q.delete();
    endtask

    task automatic model_event(input int ts);
        m_ev++;
        if (m_ev == m_n) begin
            m_ev = 0;
            if (exp_q.size() == 4) m_ovf = 1'b1;
            else exp_q.push_back(ts);
        end
    endtask

    task automatic pulse(input int hold);
        @(negedge clk); cap_in = 1'b1; model_event(bcnt);
        repeat (hold) @(negedge clk);
        cap_in = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_div(input logic [6:0] v);
        @(negedge clk); div_wr = 1'b1; div_val = v;
        @(negedge clk); div_wr = 1'b0;
        m_ev = 0; m_n = (v < 2) ? 2 : int'(v);
    endtask

    task automatic pop_one(input string req);
        chk({req, " valid"}, int'(rd_valid), 1);
        chk({req, " data"}, int'(rd_data), exp_q.pop_front());
        rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        chk({req, " level"}, int'(fifo_level), exp_q.size());
        while (exp_q.size() > 0) pop_one(req);
        chk({req, " empty"}, int'(rd_valid), 0);
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk("R1 level", int'(fifo_level), 0);
        chk("R1 valid", int'(rd_valid), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 ovf", int'(ovf), 0);
        // R1 default divide 2, R2 timestamp of 2nd edge
        pulse(1); pulse(1);
        drain("R1_R2 default divide");

        // R4 R6 R7 table of divide runs
        foreach (VEC[i]) begin
            set_div(VEC[i][13:7]);
            for (int p = 0; p < int'(VEC[i][6:0]); p++) pulse(1);
            drain("R4_R6_R7 table");
        end

        // R3 held level counts once
        set_div(7'd2);
        pulse(6);
        chk("R3 held level", int'(fifo_level), 0);
        pulse(1);
        drain("R3 second edge");

        // R5 mid-count rewrite restarts count
        set_div(7'd3);
        pulse(1); pulse(1);
        set_div(7'd2);
        pulse(1);
        chk("R5 restart", int'(fifo_level), 0);
        pulse(1);
        drain("R5 new divide");

        // R5 event coincident with write is not counted
        set_div(7'd2);
        pulse(1);
        @(negedge clk); div_wr = 1'b1; div_val = 7'd2; cap_in = 1'b1;
        @(negedge clk); div_wr = 1'b0; cap_in = 1'b0; m_ev = 0;
        chk("R5 coincident", int'(fifo_level), 0);
        pulse(1); pulse(1);
        drain("R5 after coincident");

        // R8 overflow, R9 R10 interrupt thresholds
        do_reset();
        irq_thr = 3'd3;
        for (int p = 0; p < 4; p++) pulse(1);
        chk("R10 below thr", int'(irq), 0);
        for (int p = 0; p < 2; p++) pulse(1);
        chk("R10 at thr", int'(irq), 1);
        for (int p = 0; p < 4; p++) pulse(1);
        chk("R8 level full", int'(fifo_level), 4);
        chk("R8 ovf set", int'(ovf), int'(m_ovf));
        chk("R8 ovf model", int'(m_ovf), 1);
        pop_one("R8 kept oldest");
        chk("R10 still high", int'(irq), 1);
        pop_one("R8 order");
        chk("R10 dropped", int'(irq), 0);
        chk("R8 ovf sticky", int'(ovf), 1);
        drain("R8 rest");

        do_reset();
        irq_thr = 3'd7;
        for (int p = 0; p < 6; p++) pulse(1);
        chk("R9 thr7 at 3", int'(irq), 0);
        pulse(1); pulse(1);
        chk("R9 thr7 acts as 4", int'(irq), 1);
        irq_thr = 3'd0;
        @(negedge clk);
        chk("R9 thr0 off", int'(irq), 0);
        drain("R9 drain");

        // R11 read on empty
        rd_en = 1'b1;
        @(negedge clk); @(negedge clk); rd_en = 1'b0;
        chk("R11 level", int'(fifo_level), 0);
        chk("R11 ovf", int'(ovf), 0);
        pulse(1); pulse(1);
        drain("R11 normal after");

        report();
    end
endmodule